// File: doc/BRIEF.md
# Processor Status Register Access Unit

This unit holds a 64-bit processor status word and carries out the privileged operations that touch it. It can:

- set or clear bits of the 24-bit system-mask field under an immediate mask;
- overwrite the lower 32 bits from an operand;
- return a filtered view of the word as read data;
- reload the whole word from a saved interruption copy when an interruption handler returns.

Every one of these operations is privileged. When one is attempted at any level other than the most privileged, the word is left alone and a one-cycle fault pulse is raised.

The word also keeps a sticky flag in bit 4. The flag records that a completed instruction targeted one of the lower floating-point registers. An external strobe sets it, and only an explicit write clears it. Bit 0 is reserved and is held at zero. The user-mask field is bits 5:0:

- bit 1 selects big-endian data references;
- bit 2 enables user performance monitors;
- bit 3 forces alignment faults on unaligned data references.

The unit only stores bits 5:0. It does not act on them.

All updates are registered. An operation presented in one cycle shows its effect on the status output, the read data and the fault output after the next rising clock edge.

Top module: `status_reg_unit`

## Requirements
- R1: After reset, the status word, the read data and the fault output are all zero.
- R2: Operation code 1 (mask set) ORs `mask_i[23:0]` into status bits 23:0. Bits 63:24 are unchanged, and mask bits 31:24 have no effect.
- R3: Operation code 2 (mask clear) clears every status bit in 23:0 whose `mask_i` bit is 1. Bits 63:24 are unchanged.
- R4: Operation code 3 (low write) replaces status bits 31:0 with `mask_i[31:0]` and leaves bits 63:32 unchanged.
- R5: Operation code 4 (read) loads the read data with status bits 36:35 and 31:0 in their own positions and zero in bits 63:37 and 34:32. The read data then holds that value until the next successful read.
- R6: Operation code 5 (restore) loads all 64 status bits from `saved_i` in one cycle.
- R7: Operation codes 1 to 5 complete only when `priv_i` is 0. At any other level the status word and the read data are unchanged, and `fault_o` is 1 for exactly one cycle after the attempt. Codes 0, 6 and 7 never fault.
- R8: Status bit 0 always reads 0, whatever value is written to it.
- R9: A pulse on `fp_wr_i` sets status bit 4. The bit then stays 1 until an explicit write clears it: a low write, a restore, or a mask clear with mask bit 4 set.
- R10: When `fp_wr_i` coincides with a completed operation that writes bit 4, the operation's value for bit 4 wins. Those operations are a low write, a restore, and a mask set or clear with mask bit 4 set. Otherwise, including on a faulted attempt, the strobe still sets bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code: 0 none, 1 mask set, 2 mask clear, 3 low write, 4 read, 5 restore, 6 and 7 none |
| mask_i | input | 32 | Immediate mask for codes 1 and 2, or the low-half operand for code 3 |
| priv_i | input | 2 | Current privilege level, where 0 is most privileged |
| fp_wr_i | input | 1 | A completed instruction targeted a lower floating-point register |
| saved_i | input | 64 | Saved interruption copy of the status word |
| stat_o | output | 64 | Current status word |
| rdata_o | output | 64 | Filtered read data |
| fault_o | output | 1 | Privileged-operation fault pulse |

## Verification
A wrong internal state shows up one edge after the operation that caused it. A bad mask or write shows as a wrong status word, and a misplaced filter shows as stray bits in the read data. A missed privilege check shows as a changed word with no fault pulse. A lost or stuck sticky flag shows in bit 4 right after the strobe, or right after the explicit write that should have cleared it. Bits 36:35 and 34:32 can only be loaded by a restore, so the filter is checked with a restored pattern that has both ranges set.

// File: rtl/status_reg_unit.sv
module status_reg_unit #(
  parameter int SYS_W = 24,
  parameter int LO_W  = 32,
  parameter int STICKY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_i,
  input  logic [31:0] mask_i,
  input  logic [1:0]  priv_i,
  input  logic        fp_wr_i,
  input  logic [63:0] saved_i,
  output logic [63:0] stat_o,
  output logic [63:0] rdata_o,
  output logic        fault_o
);
  localparam logic [2:0] OP_SET = 3'd1, OP_CLR = 3'd2, OP_WLO = 3'd3,
                         OP_RD  = 3'd4, OP_RST = 3'd5;
  localparam logic [63:0] VIEW = {27'd0, 2'b11, 3'd0, {LO_W{1'b1}}};

  logic [63:0] stat_q, rdata_q, nxt;
  logic        fault_q, wr_sticky;

  wire is_priv = (op_i >= OP_SET) && (op_i <= OP_RST);
  wire allowed = is_priv && (priv_i == 2'd0);

  always_comb begin
    nxt = stat_q;
    wr_sticky = 1'b0;
    if (allowed) begin
      case (op_i)
        OP_SET: begin
          nxt[SYS_W-1:0] = stat_q[SYS_W-1:0] | mask_i[SYS_W-1:0];
          wr_sticky = mask_i[STICKY];
        end
        OP_CLR: begin
          nxt[SYS_W-1:0] = stat_q[SYS_W-1:0] & ~mask_i[SYS_W-1:0];
          wr_sticky = mask_i[STICKY];
        end
        OP_WLO: begin
          nxt[LO_W-1:0] = mask_i[LO_W-1:0];
          wr_sticky = 1'b1;
        end
        OP_RST: begin
          nxt = saved_i;
          wr_sticky = 1'b1;
        end
        default: ;
      endcase
    end
    if (fp_wr_i && !wr_sticky) nxt[STICKY] = 1'b1;
    nxt[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      stat_q  <= nxt;
      fault_q <= is_priv && !allowed;
      if (allowed && op_i == OP_RD) rdata_q <= stat_q & VIEW;
    end
  end

  assign stat_o  = stat_q;
  assign rdata_o = rdata_q;
  assign fault_o = fault_q;

  assert_bit0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[0] == 1'b0);

  assert_fault_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_priv && priv_i != 2'd0 && !fp_wr_i) |=> (fault_o && $stable(stat_q) && $stable(rdata_q)));

  assert_no_fault_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_priv |=> !fault_o);

  assert_mask_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_SET || op_i == OP_CLR) && priv_i == 2'd0) |=> stat_q[63:SYS_W] == $past(stat_q[63:SYS_W]));

  assert_wlo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WLO && priv_i == 2'd0) |=>
      (stat_q[63:LO_W] == $past(stat_q[63:LO_W]) && stat_q[LO_W-1:1] == $past(mask_i[LO_W-1:1])));

  assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RST && priv_i == 2'd0) |=> stat_q[63:1] == $past(saved_i[63:1]));

  assert_read_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RD && priv_i == 2'd0) |=> (rdata_q[63:37] == '0 && rdata_q[34:32] == '0 &&
      rdata_q[31:0] == $past(stat_q[31:0])));

  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_wr_i && !is_priv) |=> stat_q[STICKY]);
endmodule

// File: tb/status_reg_unit_tb_top.sv
`timescale 1ns/1ps
module status_reg_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op_i = '0;
  logic [31:0] mask_i = '0;
  logic [1:0] priv_i = '0;
  logic fp_wr_i = 1'b0;
  logic [63:0] saved_i = '0;
  logic [63:0] stat_o, rdata_o;
  logic fault_o;
  int total = 0, bad = 0;
  logic [63:0] exp_stat, exp_rd;

  always #2 clk = ~clk;

  status_reg_unit dut_i (.clk(clk), .rst_n(rst_n), .op_i(op_i), .mask_i(mask_i),
    .priv_i(priv_i), .fp_wr_i(fp_wr_i), .saved_i(saved_i), .stat_o(stat_o),
    .rdata_o(rdata_o), .fault_o(fault_o));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, expv);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] m, input logic [1:0] pv,
                       input logic fp, input logic [63:0] sv);
    op_i = op; mask_i = m; priv_i = pv; fp_wr_i = fp; saved_i = sv;
    @(negedge clk);
    op_i = '0; mask_i = '0; priv_i = '0; fp_wr_i = 1'b0; saved_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 stat", stat_o, 64'h0);
    chk("R1 rdata", rdata_o, 64'h0);
    chk("R1 fault", {63'd0, fault_o}, 64'h0);
  endtask

  task automatic t_restore;
    issue(3'd5, 32'h0, 2'd0, 1'b0, 64'hF0F0_001F_A5A5_5A5B);
    exp_stat = 64'hF0F0_001F_A5A5_5A5A;
    chk("R6 restore", stat_o, exp_stat);
    chk("R8 bit0 after restore", {63'd0, stat_o[0]}, 64'h0);
  endtask

  task automatic t_mask_ops;
    issue(3'd1, 32'hFF00_0F01, 2'd0, 1'b0, 64'h0);
    exp_stat = 64'hF0F0_001F_A5A5_5F5A;
    chk("R2 mask set", stat_o, exp_stat);
    issue(3'd2, 32'hFF00_00F0, 2'd0, 1'b0, 64'h0);
    exp_stat = 64'hF0F0_001F_A5A5_5F0A;
    chk("R3 mask clear", stat_o, exp_stat);
  endtask

  task automatic t_write_lo;
    issue(3'd3, 32'h1234_5679, 2'd0, 1'b0, 64'h0);
    exp_stat = 64'hF0F0_001F_1234_5678;
    chk("R4 low write", stat_o, exp_stat);
    chk("R8 bit0 after write", {63'd0, stat_o[0]}, 64'h0);
  endtask

  task automatic t_read;
    issue(3'd4, 32'h0, 2'd0, 1'b0, 64'h0);
    exp_rd = 64'h0000_0018_1234_5678;
    chk("R5 read view", rdata_o, exp_rd);
    issue(3'd3, 32'h0000_0000, 2'd0, 1'b0, 64'h0);
    chk("R5 read held", rdata_o, exp_rd);
    issue(3'd3, 32'h1234_5678, 2'd0, 1'b0, 64'h0);
  endtask

  task automatic t_priv;
    issue(3'd3, 32'hFFFF_FFFF, 2'd2, 1'b0, 64'h0);
    chk("R7 faulted write stat", stat_o, exp_stat);
    chk("R7 fault pulse", {63'd0, fault_o}, 64'h1);
    @(negedge clk);
    chk("R7 fault one cycle", {63'd0, fault_o}, 64'h0);
    issue(3'd5, 32'h0, 2'd1, 1'b0, 64'h0);
    chk("R7 faulted restore stat", stat_o, exp_stat);
    chk("R7 fault on restore", {63'd0, fault_o}, 64'h1);
    issue(3'd4, 32'h0, 2'd3, 1'b0, 64'h0);
    chk("R7 faulted read rdata", rdata_o, exp_rd);
    issue(3'd0, 32'hFFFF_FFFF, 2'd3, 1'b0, 64'h0);
    chk("R7 idle no fault", {63'd0, fault_o}, 64'h0);
    issue(3'd7, 32'hFFFF_FFFF, 2'd3, 1'b0, 64'h0);
    chk("R7 code7 no fault", {63'd0, fault_o}, 64'h0);
    chk("R7 code7 stat", stat_o, exp_stat);
  endtask

  task automatic t_sticky;
    issue(3'd3, 32'h1234_5668, 2'd0, 1'b0, 64'h0);
    chk("R9 cleared by write", stat_o[31:0], 64'h1234_5668);
    issue(3'd0, 32'h0, 2'd0, 1'b1, 64'h0);
    chk("R9 strobe sets", stat_o[31:0], 64'h1234_5678);
    issue(3'd1, 32'h0000_0002, 2'd0, 1'b0, 64'h0);
    chk("R9 survives set", stat_o[31:0], 64'h1234_567A);
    issue(3'd2, 32'h0000_0010, 2'd0, 1'b0, 64'h0);
    chk("R9 cleared by mask clear", stat_o[31:0], 64'h1234_566A);
  endtask

  task automatic t_collide;
    issue(3'd3, 32'h0000_0000, 2'd0, 1'b1, 64'h0);
    chk("R10 write wins", stat_o[31:0], 64'h0);
    issue(3'd1, 32'h0000_0002, 2'd0, 1'b1, 64'h0);
    chk("R10 strobe with set", stat_o[31:0], 64'h12);
    issue(3'd2, 32'h0000_0010, 2'd0, 1'b1, 64'h0);
    chk("R10 clear wins", stat_o[31:0], 64'h2);
    issue(3'd3, 32'h0, 2'd1, 1'b1, 64'h0);
    chk("R10 strobe on fault", stat_o[31:0], 64'h12);
    chk("R7 fault with strobe", {63'd0, fault_o}, 64'h1);
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_stat = '0; exp_rd = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_restore;
    t_mask_ops;
    t_write_lo;
    t_read;
    t_priv;
    t_sticky;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule